// File: doc/BRIEF.md
# MSI snooping coherence controller

This block keeps the coherence state of a small write-back cache that shares a snooping bus with other caches. The cache is direct-mapped. Each slot holds one data word, a tag and a two-bit state: Invalid, Shared or Modified. The local processor sends read and write requests. The block answers hits at once and turns misses, upgrades and evictions into bus transactions. While a transaction waits for the bus, the block holds it on a request/grant handshake and refuses new local requests. The memory behind the bus belongs to the surrounding system.

Transactions from other caches arrive on a snoop port, which the block watches. When another cache writes a line that this cache holds, the local copy is dropped. When another cache reads a line held Modified, the block places the dirty word on a writeback port and keeps the line as Shared. A write to a Shared line needs only a short invalidate with no data. The line then becomes Modified and memory is left stale until a later writeback.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every slot is Invalid, `req_ready` is high and `bus_req` is low. Slot i's state sits at `line_st[2*i+1:2*i]`, coded Invalid=00, Shared=01, Modified=10. The slot index is the low log2(LINES) address bits, and the tag is the remaining upper bits.
- R2: A read whose slot is Invalid, or holds another tag, issues a bus read (`bus_cmd`=0) for the request address. The word returned on `bus_rdata` in the grant cycle is answered on `rsp_rdata`, and the slot becomes Shared.
- R3: A write to a Shared hit issues only an invalidate (`bus_cmd`=2) for the address, with no data and no other bus transaction. After the grant the slot is Modified and holds the new word.
- R4: A read hit on a Shared or Modified slot and a write hit on a Modified slot create no bus request. `rsp_valid` rises in the cycle after the request is accepted, and a read returns the stored word.
- R5: A snooped write (`snp_write`=1) that matches a Shared or Modified slot makes the slot Invalid and gives no snoop response.
- R6: A snooped read that matches a Modified slot drives `snp_wb_valid` for one cycle, starting the cycle after the snoop. It carries the snooped address and the slot's word, and the slot becomes Shared. A snooped read that matches a Shared slot changes nothing.
- R7: A miss whose slot holds another line in Modified state first issues a writeback (`bus_cmd`=3). The writeback carries the victim's address and word. The fetch follows, and the slot reads Invalid while that fetch waits for its grant.
- R8: A write whose slot is Invalid, or holds another tag, issues a read-for-ownership (`bus_cmd`=1) for the address. After the grant the slot is Modified and holds the written word.
- R9: While `bus_req` is high, `req_ready` is low, and `bus_cmd` and `bus_addr` stay steady until `bus_gnt`.
- R10: A snoop whose address is not held in any valid slot changes no state and raises no `snp_wb_valid`.
- R11: A bus transaction completes on the clock edge where `bus_gnt` is sampled high. A request that ends with that transaction raises `rsp_valid` in the following cycle, together with `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Local word address |
| req_wdata | input | DATA_W | Local write data |
| req_ready | output | 1 | Block can accept a local request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read result |
| bus_req | output | 1 | Own bus transaction waiting for grant |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_addr | output | ADDR_W | Address of own transaction |
| bus_wdata | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Grant; completes the transaction this cycle |
| bus_rdata | input | DATA_W | Fill data valid with the grant |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wb_valid | output | 1 | Dirty data supplied for a snooped read |
| snp_wb_addr | output | ADDR_W | Address of supplied data |
| snp_wb_data | output | DATA_W | Supplied dirty word |
| line_st | output | 2*LINES | Per-slot coherence states |

## Verification
A hit answers one cycle after the accepting edge. A miss or upgrade answers one cycle after the edge that samples `bus_gnt`. A snoop changes state and gives its writeback one cycle after its own edge. Every bus phase is checked before its grant, and the grant is held back a random 0 to 2 cycles so that the stall and hold rules are exercised. The bench drives inputs and samples every output on the falling edge, after the registers have settled. Each operation is completed and checked before the next one starts, so every expected value refers to one known edge.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                bus_req,
  output logic [1:0]          bus_cmd,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_gnt,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                snp_valid,
  input  logic                snp_write,
  input  logic [ADDR_W-1:0]   snp_addr,
  output logic                snp_wb_valid,
  output logic [ADDR_W-1:0]   snp_wb_addr,
  output logic [DATA_W-1:0]   snp_wb_data,
  output logic [2*LINES-1:0]  line_st
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_M = 2'b10;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_INV = 2'd2, CMD_WB = 2'd3;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_FETCH, F_UPG} fsm_t;

  fsm_t              fsm_q;
  logic [1:0]        st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic [ADDR_W-1:0] p_addr;
  logic              p_write;
  logic [DATA_W-1:0] p_wdata;

  wire [IDX_W-1:0] p_idx = p_addr[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = p_addr[ADDR_W-1:IDX_W];

  // snoop lookup
  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];
  wire       s_hit = snp_valid && (tag_q[s_idx] == s_tag) && (st_q[s_idx] != ST_I);
  wire       s_sup = s_hit && !snp_write && (st_q[s_idx] == ST_M);
  wire [1:0] s_new = snp_write ? ST_I : ((st_q[s_idx] == ST_M) ? ST_S : st_q[s_idx]);

  // local lookup, seen after any same-cycle snoop
  wire [IDX_W-1:0] r_idx   = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0] r_tag   = req_addr[ADDR_W-1:IDX_W];
  wire             r_tagok = (tag_q[r_idx] == r_tag);
  wire [1:0]       r_st    = (s_hit && s_idx == r_idx) ? s_new : st_q[r_idx];
  wire             r_hit   = r_tagok && (r_st != ST_I);
  wire             accept  = req_valid && (fsm_q == F_IDLE);
  wire             s_on_p  = s_hit && (s_idx == p_idx);

  assign req_ready = (fsm_q == F_IDLE);
  assign bus_req   = (fsm_q != F_IDLE);
  assign bus_cmd   = (fsm_q == F_WB)  ? CMD_WB  :
                     (fsm_q == F_UPG) ? CMD_INV :
                     (p_write ? CMD_RDX : CMD_RD);
  assign bus_addr  = (fsm_q == F_WB) ? {tag_q[p_idx], p_idx} : p_addr;
  assign bus_wdata = (fsm_q == F_WB) ? dat_q[p_idx] : '0;

  for (genvar g = 0; g < LINES; g++) begin : g_st
    assign line_st[2*g +: 2] = st_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q        <= F_IDLE;
      rsp_valid    <= 1'b0;
      snp_wb_valid <= 1'b0;
      p_addr       <= '0;
      p_write      <= 1'b0;
      p_wdata      <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      rsp_valid    <= 1'b0;
      snp_wb_valid <= 1'b0;
      if (s_hit) begin
        st_q[s_idx] <= s_new;
        if (s_sup) begin
          snp_wb_valid <= 1'b1;
          snp_wb_addr  <= snp_addr;
          snp_wb_data  <= dat_q[s_idx];
        end
      end
      case (fsm_q)
        F_IDLE: if (accept) begin
          p_addr  <= req_addr;
          p_write <= req_write;
          p_wdata <= req_wdata;
          if (r_hit && (!req_write || r_st == ST_M)) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dat_q[r_idx];
            if (req_write) dat_q[r_idx] <= req_wdata;
          end else if (r_hit) begin
            fsm_q <= F_UPG;
          end else if (r_st == ST_M) begin
            fsm_q <= F_WB;
          end else begin
            fsm_q       <= F_FETCH;
            st_q[r_idx] <= ST_I;
          end
        end
        F_WB: if (s_on_p || bus_gnt) begin
          fsm_q       <= F_FETCH;
          st_q[p_idx] <= ST_I;
        end
        F_FETCH: if (bus_gnt) begin
          fsm_q       <= F_IDLE;
          tag_q[p_idx] <= p_tag;
          dat_q[p_idx] <= p_write ? p_wdata : bus_rdata;
          st_q[p_idx]  <= p_write ? ST_M : ST_S;
          rsp_valid    <= 1'b1;
          rsp_rdata    <= bus_rdata;
        end
        F_UPG: if (s_on_p && snp_write) begin
          fsm_q <= F_FETCH;
        end else if (bus_gnt) begin
          fsm_q        <= F_IDLE;
          st_q[p_idx]  <= ST_M;
          dat_q[p_idx] <= p_wdata;
          rsp_valid    <= 1'b1;
          rsp_rdata    <= p_wdata;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  AST_STALL_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready); // R9
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R9
  AST_M_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && r_hit && r_st == ST_M) |=> (!bus_req && rsp_valid)); // R4
  AST_S_WRITE_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && r_hit && r_st == ST_S) |=> (bus_req && bus_cmd == CMD_INV)); // R3
  AST_SNOOP_WRITE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && snp_write) |=> (st_q[$past(s_idx)] == ST_I && !snp_wb_valid)); // R5
  AST_SNOOP_READ_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sup && fsm_q == F_IDLE && !req_valid) |=> (snp_wb_valid && st_q[$past(s_idx)] == ST_S)); // R6
  AST_NO_SNOOP_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_hit) |=> !snp_wb_valid); // R10
endmodule

// File: tb/msi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_tb_top;
  localparam int LINES = 4, ADDR_W = 8, DATA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, bus_req, snp_wb_valid;
  logic [DATA_W-1:0] rsp_rdata, bus_wdata, snp_wb_data;
  logic [1:0] bus_cmd;
  logic [ADDR_W-1:0] bus_addr, snp_wb_addr;
  logic bus_gnt = 0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic snp_valid = 0, snp_write = 0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [2*LINES-1:0] line_st;

  always #5 clk = ~clk;

  msi_snoop_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .snp_valid(snp_valid),
    .snp_write(snp_write), .snp_addr(snp_addr), .snp_wb_valid(snp_wb_valid),
    .snp_wb_addr(snp_wb_addr), .snp_wb_data(snp_wb_data), .line_st(line_st));

  int total = 0, bad = 0;
  logic [DATA_W-1:0] mem [256];
  logic [1:0]        m_st  [LINES];
  logic [5:0]        m_tag [LINES];
  logic [DATA_W-1:0] m_dat [LINES];
  logic [1:0]        e_cmd  [2];
  logic [ADDR_W-1:0] e_addr [2];
  logic [DATA_W-1:0] e_data [2];
  int n_exp;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [2*LINES-1:0] exp_st();
    logic [2*LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[2*i +: 2] = m_st[i];
    return v;
  endfunction

  task automatic push(input logic [1:0] c, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    e_cmd[n_exp] = c; e_addr[n_exp] = a; e_data[n_exp] = d; n_exp++;
  endtask

  task automatic local_op(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd);
    int idx = int'(a[1:0]);
    logic [5:0] tg = a[7:2];
    bit hit = (m_tag[idx] == tg) && (m_st[idx] != 2'b00);
    logic [DATA_W-1:0] exp_rd = '0;
    string rq;
    int k = 0, cyc = 0;
    bit got = 0;
    n_exp = 0;
    if (!wr) begin
      if (hit) begin rq = "R4"; exp_rd = m_dat[idx]; end
      else begin
        rq = "R2";
        if (m_st[idx] == 2'b10) begin rq = "R7"; push(2'd3, {m_tag[idx], a[1:0]}, m_dat[idx]); end
        push(2'd0, a, '0);
        exp_rd = mem[a];
        m_tag[idx] = tg; m_dat[idx] = mem[a]; m_st[idx] = 2'b01;
      end
    end else begin
      if (hit && m_st[idx] == 2'b10) rq = "R4";
      else if (hit) begin rq = "R3"; push(2'd2, a, '0); end
      else begin
        rq = "R8";
        if (m_st[idx] == 2'b10) begin rq = "R7"; push(2'd3, {m_tag[idx], a[1:0]}, m_dat[idx]); end
        push(2'd1, a, '0);
      end
      m_tag[idx] = tg; m_dat[idx] = wd; m_st[idx] = 2'b10;
    end
    @(negedge clk);
    chk("R11", "req_ready idle", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk); #1 req_valid = 0;
    while (!got && cyc < 40) begin
      @(negedge clk); cyc++;
      if (rsp_valid) begin
        got = 1;
        if (!wr) chk(rq, "read data", rsp_rdata, exp_rd);
        if (n_exp == 0) chk("R4", "hit latency", cyc, 1);
      end else if (bus_req) begin
        int d = int'($urandom % 3);
        chk("R9", "ready low while bus_req", req_ready, 0);
        chk(rq, "extra bus transaction", (k < n_exp), 1);
        if (k < n_exp) begin
          chk(rq, "bus_cmd", bus_cmd, e_cmd[k]);
          chk(rq, "bus_addr", bus_addr, e_addr[k]);
          if (e_cmd[k] == 2'd3) chk("R7", "writeback data", bus_wdata, e_data[k]);
          if (e_cmd[k] <= 2'd1) chk("R7", "slot invalid during fetch", line_st[2*idx +: 2], 0);
        end
        repeat (d) begin
          @(negedge clk);
          chk("R9", "bus_req held", bus_req, 1);
        end
        bus_gnt = 1; bus_rdata = mem[bus_addr];
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
        @(posedge clk); #1 bus_gnt = 0; k++;
      end
    end
    chk("R11", "response seen", got, 1);
    chk(rq, "bus transaction count", k, n_exp);
    chk(rq, "line states", line_st, exp_st());
  endtask

  task automatic snoop_op(input bit wr, input logic [ADDR_W-1:0] a);
    int idx = int'(a[1:0]);
    bit hit = (m_tag[idx] == a[7:2]) && (m_st[idx] != 2'b00);
    bit sup = hit && !wr && (m_st[idx] == 2'b10);
    string rq = !hit ? "R10" : (wr ? "R5" : "R6");
    @(negedge clk);
    snp_valid = 1; snp_write = wr; snp_addr = a;
    @(posedge clk); #1 snp_valid = 0;
    @(negedge clk);
    chk(rq, "snp_wb_valid", snp_wb_valid, sup);
    if (sup) begin
      chk("R6", "snp_wb_addr", snp_wb_addr, a);
      chk("R6", "snp_wb_data", snp_wb_data, m_dat[idx]);
    end
    if (hit) m_st[idx] = wr ? 2'b00 : ((m_st[idx] == 2'b10) ? 2'b01 : m_st[idx]);
    chk(rq, "line states", line_st, exp_st());
    chk(rq, "no bus traffic", bus_req, 0);
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0131 ^ 16'h5a00);
    for (int i = 0; i < LINES; i++) begin m_st[i] = 2'b00; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "reset states", line_st, 0);
    chk("R1", "reset ready", req_ready, 1);
    chk("R1", "reset bus_req", bus_req, 0);
    local_op(0, 8'h05, 0);       // R2 read miss
    local_op(0, 8'h05, 0);       // R4 read hit S
    local_op(1, 8'h05, 16'h1111);// R3 upgrade
    local_op(0, 8'h05, 0);       // R4 read hit M
    local_op(1, 8'h05, 16'h2222);// R4 write hit M
    snoop_op(0, 8'h05);          // R6 supply, M->S
    snoop_op(0, 8'h05);          // R6 read on S: nothing
    snoop_op(1, 8'h05);          // R5 invalidate
    snoop_op(1, 8'h09);          // R10 absent
    local_op(1, 8'h06, 16'h3333);// R8 write miss
    local_op(0, 8'h0A, 0);       // R7 eviction of M
    local_op(1, 8'h13, 16'h4444);// R8
    snoop_op(0, 8'h07);          // R10 other tag
    local_op(1, 8'h17, 16'h5555);// R7 write miss over M
    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a = ADDR_W'($urandom % 32);
      if (($urandom % 10) < 7) local_op(bit'($urandom % 2), a, DATA_W'($urandom));
      else snoop_op(bit'($urandom % 2), a);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule